// File: doc/BRIEF.md
# Serial Waveform Sample Streamer

This block sends frames of 32-bit waveform samples out of the chip over a three-wire serial link that it drives as the master. The link has a serial clock output, a data output and a frame-select output. Sample producers place seven words on a wide parallel input and pulse a start strobe. The block then shifts the whole frame out, most significant bit first. The frame is six current-channel samples followed by one voltage sample. The block accepts no new frame until the current one is finished.

A six-bit configuration register controls the frame format. It sets the frame-select polarity, the serial clock rate, and whether each word goes out as one 32-bit package or as four 8-bit packages. It also enables a fixed idle gap between packages and holds the transfer code that permits streaming. The block captures this configuration when a frame starts, so software may rewrite it at any time without corrupting a frame in flight.

Top module: `wave_streamer`

## Requirements
- R1: After reset, cfg_q reads 0, busy_o is 0, sclk_o is 1, ssel_o is 1 (inactive for polarity 0) and sdata_o is 0.
- R2: When cfg_we is high, cfg_wdata is stored and appears on cfg_q in the next cycle. The bit layout is: bit 0 select polarity, bit 1 slow clock, bit 2 gap enable, bit 3 byte packages, bits [5:4] transfer code.
- R3: Code 01 (waveform) enables streaming. A start pulse while idle then sends 224 bits. Word k is frame_data[32k+31:32k], words go out in order 0 to 6 (words 0 to 5 are currents, word 6 is voltage), and each word goes out MSB first.
- R4: sdata_o changes only on a falling edge of sclk_o during a frame, so each bit is stable when sclk_o rises. sclk_o rests high while no frame is running.
- R5: With polarity 0, ssel_o is low for the whole frame, gaps included, and high otherwise. Polarity 1 inverts both levels.
- R6: A serial clock period lasts 2 clk cycles (1 low, 1 high) when the slow bit is 0, and 4 clk cycles (2 low, 2 high) when it is 1.
- R7: When the byte-package bit is 0, a package is 32 bits. When it is 1, a package is 8 bits. When the gap bit is set, sclk_o is held high for exactly 7 serial clock periods between consecutive packages, and no gap follows the last package.
- R8: busy_o rises in the cycle after an accepted start. It stays high for exactly the sum of all bit periods and gap periods of the frame, then falls.
- R9: A start pulse with transfer code 00, 10 or 11 starts no frame: busy_o stays low, sclk_o stays high and ssel_o stays inactive.
- R10: The configuration and frame_data are captured at the start of a frame. Writes to them during the frame affect only later frames.
- R11: A start pulse that arrives while busy_o is high is ignored, and no frame follows the current one because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 6 | Configuration write value |
| cfg_q | output | 6 | Current configuration register value |
| start | input | 1 | Frame start strobe |
| frame_data | input | 224 | Seven 32-bit samples, word k at bits [32k+31:32k] |
| sclk_o | output | 1 | Serial clock, idle high |
| sdata_o | output | 1 | Serial data, MSB first |
| ssel_o | output | 1 | Frame select, polarity from configuration |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench streams frames in four format corners:
- 32-bit packages at the fast rate with no gap.
- Byte packages at the slow rate with gaps.
- Byte packages at the fast rate with no gap.
- 32-bit packages at the slow rate with gaps.

Each frame uses different data, and each corner uses its own select polarity. A receiver model timestamps every rising clock edge. The spacing between edges separates the clock-rate setting from the package-size and gap settings, and comparing the received bits against the words exposes any error in word order or bit order. Further cases rewrite the register and data in mid-frame and pulse start while busy, which tells captured settings apart from live ones. Pulses with the non-streaming codes confirm that those codes start nothing.

// File: rtl/wstr_pkg.sv
`timescale 1ns/1ps
package wstr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } wstr_state_e;

  localparam logic [1:0] XFER_WAVE = 2'b01;

  // Packed so that the vector layout is {xfer[5:4], byte_pkg[3], gap_en[2], slow[1], sel_pol[0]}
  typedef struct packed {
    logic [1:0] xfer;
    logic       byte_pkg;
    logic       gap_en;
    logic       slow;
    logic       sel_pol;
  } wstr_cfg_t;

  // Half of one serial clock period in system clock cycles
  function automatic int unsigned half_period(logic slow, int unsigned half_fast);
    return slow ? 2 * half_fast : half_fast;
  endfunction

  // Total busy cycles of one frame for a given format
  function automatic int unsigned frame_cycles(logic byte_pkg, logic gap_en, logic slow,
                                               int unsigned half_fast, int unsigned n_words,
                                               int unsigned word_w, int unsigned byte_w,
                                               int unsigned gap_clks);
    int unsigned per;
    int unsigned pkgs;
    per  = 2 * half_period(slow, half_fast);
    pkgs = byte_pkg ? n_words * (word_w / byte_w) : n_words;
    return n_words * word_w * per + (gap_en ? (pkgs - 1) * gap_clks * per : 0);
  endfunction

endpackage

// File: rtl/wstr_cfg_reg.sv
`timescale 1ns/1ps
module wstr_cfg_reg
  import wstr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  output wstr_cfg_t  cfg_r
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_r <= '0;
    else if (cfg_we) cfg_r <= wstr_cfg_t'(cfg_wdata);
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(cfg_r));

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_r == wstr_cfg_t'($past(cfg_wdata)));

endmodule

// File: rtl/wstr_baud.sv
`timescale 1ns/1ps
module wstr_baud #(
  parameter int unsigned HALF_FAST = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic sclk_hi,
  output logic per_end
);

  localparam int unsigned MAX_PER = 4 * HALF_FAST;
  localparam int unsigned CW      = $clog2(MAX_PER + 1);

  logic [CW-1:0] ph;
  logic [CW-1:0] last_ph;
  logic [CW-1:0] half_lvl;

  assign half_lvl = slow ? CW'(2 * HALF_FAST) : CW'(HALF_FAST);
  assign last_ph  = slow ? CW'(4 * HALF_FAST - 1) : CW'(2 * HALF_FAST - 1);
  assign per_end  = run && (ph == last_ph);
  assign sclk_hi  = ph >= half_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ph <= '0;
    else if (!run || per_end)   ph <= '0;
    else                        ph <= ph + CW'(1);
  end

  // R6
  ph_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph < CW'(MAX_PER));

  // R6
  ph_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> ph == '0);

endmodule

// File: rtl/wstr_shifter.sv
`timescale 1ns/1ps
module wstr_shifter #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_WORDS = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        shift,
  input  logic [N_WORDS*WORD_W-1:0]   words,
  output logic                        sdata
);

  localparam int unsigned FB = N_WORDS * WORD_W;

  logic [FB-1:0] ordered;
  logic [FB-1:0] sr;

  // Word 0 is placed at the top so that it leaves first
  for (genvar k = 0; k < N_WORDS; k++) begin : g_order
    assign ordered[FB-1-k*WORD_W -: WORD_W] = words[k*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (load)   sr <= ordered;
    else if (shift)  sr <= {sr[FB-2:0], 1'b0};
  end

  assign sdata = sr[FB-1];

  // R3
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/wave_streamer.sv
`timescale 1ns/1ps
module wave_streamer
  import wstr_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned N_WORDS   = 7,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned HALF_FAST = 1,
  parameter int unsigned GAP_CLKS  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [5:0]                cfg_wdata,
  output logic [5:0]                cfg_q,
  input  logic                      start,
  input  logic [N_WORDS*WORD_W-1:0] frame_data,
  output logic                      sclk_o,
  output logic                      sdata_o,
  output logic                      ssel_o,
  output logic                      busy_o
);

  localparam int unsigned N_PKG_MAX = N_WORDS * (WORD_W / BYTE_W);
  localparam int unsigned BCW       = $clog2(WORD_W);
  localparam int unsigned PCW       = $clog2(N_PKG_MAX + 1);
  localparam int unsigned GCW       = $clog2(GAP_CLKS + 1);
  localparam int unsigned RCW       = 24;

  wstr_cfg_t   cfg_r;
  wstr_cfg_t   cap;
  wstr_state_e state;
  logic [BCW-1:0] bit_cnt;
  logic [PCW-1:0] pkg_left;
  logic [GCW-1:0] gap_cnt;

  logic in_send, in_gap, run;
  logic sclk_hi, per_end;
  logic last_bit, last_pkg;
  logic accept;
  logic ev_bit_end, ev_pkg_end, ev_frame_end, ev_gap_enter, ev_gap_end;
  logic shift;

  wstr_cfg_reg i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_r     (cfg_r)
  );

  assign cfg_q = cfg_r;

  assign in_send = (state == ST_SEND);
  assign in_gap  = (state == ST_GAP);
  assign run     = (state != ST_IDLE);

  wstr_baud #(.HALF_FAST(HALF_FAST)) i_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .slow    (cap.slow),
    .sclk_hi (sclk_hi),
    .per_end (per_end)
  );

  // Named events
  assign accept       = start && (state == ST_IDLE) && (cfg_r.xfer == XFER_WAVE);
  assign last_bit     = cap.byte_pkg ? (bit_cnt == BCW'(BYTE_W - 1)) : (bit_cnt == BCW'(WORD_W - 1));
  assign last_pkg     = (pkg_left == PCW'(1));
  assign ev_bit_end   = in_send && per_end;
  assign ev_pkg_end   = ev_bit_end && last_bit;
  assign ev_frame_end = ev_pkg_end && last_pkg;
  assign ev_gap_enter = ev_pkg_end && !last_pkg && cap.gap_en;
  assign ev_gap_end   = in_gap && per_end && (gap_cnt == GCW'(GAP_CLKS - 1));
  // Data moves on a falling serial edge: the shift that would land inside a gap is held until the gap ends
  assign shift        = (ev_bit_end && !ev_gap_enter) || ev_gap_end;

  wstr_shifter #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) i_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (shift),
    .words (frame_data),
    .sdata (sdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cap      <= '0;
      bit_cnt  <= '0;
      pkg_left <= '0;
      gap_cnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cap      <= cfg_r;
            state    <= ST_SEND;
            bit_cnt  <= '0;
            pkg_left <= cfg_r.byte_pkg ? PCW'(N_PKG_MAX) : PCW'(N_WORDS);
          end
        end
        ST_SEND: begin
          if (ev_bit_end) begin
            if (last_bit) begin
              bit_cnt <= '0;
              if (last_pkg) begin
                state <= ST_IDLE;
              end else begin
                pkg_left <= pkg_left - PCW'(1);
                if (cap.gap_en) begin
                  state   <= ST_GAP;
                  gap_cnt <= '0;
                end
              end
            end else begin
              bit_cnt <= bit_cnt + BCW'(1);
            end
          end
        end
        ST_GAP: begin
          if (per_end) begin
            if (gap_cnt == GCW'(GAP_CLKS - 1)) state <= ST_SEND;
            else                               gap_cnt <= gap_cnt + GCW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = run;
  assign sclk_o = in_send ? sclk_hi : 1'b1;
  assign ssel_o = run ? cap.sel_pol : ~cfg_r.sel_pol;

  // Frame length checker
  logic [RCW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (!run) run_cnt <= '0;
    else           run_cnt <= run_cnt + RCW'(1);
  end

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end |-> (32'(run_cnt) + 32'd1 ==
      frame_cycles(cap.byte_pkg, cap.gap_en, cap.slow, HALF_FAST, N_WORDS, WORD_W, BYTE_W, GAP_CLKS)));

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o);

  // R4
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o && (sdata_o != $past(sdata_o))) |-> $fell(sclk_o));

  // R7
  gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (sclk_o && busy_o));

  // R10
  cap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o) |-> $stable(cap));

  // R9
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o && (cfg_r.xfer != XFER_WAVE)) |=> !busy_o);

  // R9
  cap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cap.xfer == XFER_WAVE);

  // R7
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap.byte_pkg |-> bit_cnt < BCW'(BYTE_W));

endmodule

// File: tb/test_wave_streamer.sv
`timescale 1ns/1ps
module test_wave_streamer;

  localparam int WW = 32;
  localparam int NW = 7;
  localparam int BW = 8;
  localparam int HF = 1;
  localparam int GC = 7;
  localparam int FB = NW * WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_q;
  logic start = 1'b0;
  logic [FB-1:0] frame_data = '0;
  logic sclk_o, sdata_o, ssel_o, busy_o;

  always #2.5 clk = ~clk;

  wave_streamer #(.WORD_W(WW), .N_WORDS(NW), .BYTE_W(BW), .HALF_FAST(HF), .GAP_CLKS(GC))
  i_wave_streamer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .start(start), .frame_data(frame_data), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .ssel_o(ssel_o), .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;

  // Receiver model, sampled at the falling system clock edge
  int cyc = 0;
  int nbits = 0;
  logic [FB-1:0] got;
  int edge_t [FB];
  int busy_cnt = 0;
  int sel_err = 0;
  int dchg_err = 0;
  logic mon_pol = 1'b0;
  logic prev_sclk = 1'b1;
  logic prev_sd = 1'b0;
  logic prev_busy = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (busy_o) begin
      busy_cnt++;
      if (ssel_o !== mon_pol) sel_err++;
      if (prev_busy && (sdata_o !== prev_sd) && !(prev_sclk && !sclk_o)) dchg_err++;
    end
    if (!prev_sclk && sclk_o) begin
      if (nbits < FB) begin
        got[FB-1-nbits] = sdata_o;
        edge_t[nbits] = cyc;
      end
      nbits++;
    end
    prev_sclk = sclk_o;
    prev_sd   = sdata_o;
    prev_busy = busy_o;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    nbits = 0; busy_cnt = 0; sel_err = 0; dchg_err = 0; got = '0;
  endtask

  task automatic write_cfg(logic [5:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [5:0] mk_cfg(bit byte_m, bit gap, bit slow, bit pol, logic [1:0] code);
    logic [5:0] v;
    v = '0;
    v[0] = pol; v[1] = slow; v[2] = gap; v[3] = byte_m; v[5:4] = code;
    return v;
  endfunction

  function automatic logic [FB-1:0] mk_data(int seed);
    logic [FB-1:0] d;
    for (int k = 0; k < NW; k++) d[k*WW +: WW] = 32'h9E37_79B9 * (seed + k + 1) ^ {seed[7:0], 8'(k), 16'hA55A};
    return d;
  endfunction

  function automatic logic [FB-1:0] expect_stream(logic [FB-1:0] d);
    logic [FB-1:0] e;
    for (int k = 0; k < NW; k++) e[FB-1-k*WW -: WW] = d[k*WW +: WW];
    return e;
  endfunction

  function automatic int expect_len(bit byte_m, bit gap, bit slow);
    int per, pbits, pkgs, len;
    per = slow ? 4 * HF : 2 * HF;
    pbits = byte_m ? BW : WW;
    pkgs = FB / pbits;
    len = 0;
    for (int p = 0; p < pkgs; p++) begin
      len += pbits * per;
      if (gap && p != pkgs - 1) len += GC * per;
    end
    return len;
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cfg_q == 6'd0, "R1", "cfg_q after reset", cfg_q, 0);
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(sclk_o == 1'b1, "R1", "sclk idle level", sclk_o, 1);
    chk(ssel_o == 1'b1, "R1", "ssel inactive level", ssel_o, 1);
    chk(sdata_o == 1'b0, "R1", "sdata after reset", sdata_o, 0);
  endtask

  task automatic t_cfg_rw();
    write_cfg(6'h2A);
    chk(cfg_q == 6'h2A, "R2", "cfg readback", cfg_q, 6'h2A);
    chk(ssel_o == 1'b1, "R5", "ssel idle with pol 0", ssel_o, 1);
    write_cfg(6'h00);
  endtask

  task automatic t_frame(bit byte_m, bit gap, bit slow, bit pol, int seed);
    logic [FB-1:0] d, e;
    int per, pbits, bad_iv, exp_d, bad_bits;
    d = mk_data(seed);
    e = expect_stream(d);
    per = slow ? 4 * HF : 2 * HF;
    pbits = byte_m ? BW : WW;
    write_cfg(mk_cfg(byte_m, gap, slow, pol, 2'b01));
    chk(ssel_o == ~pol, "R5", "ssel inactive before frame", ssel_o, ~pol);
    frame_data = d;
    mon_pol = pol;
    clear_mon();
    pulse_start();
    chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
    wait_idle();
    @(negedge clk);
    bad_bits = $countones(got ^ e);
    chk(nbits == FB, "R3", "rising edge count", nbits, FB);
    chk(bad_bits == 0, "R3", "received bits differing", bad_bits, 0);
    chk(busy_cnt == expect_len(byte_m, gap, slow), "R8", "busy length", busy_cnt, expect_len(byte_m, gap, slow));
    chk(sel_err == 0, "R5", "ssel not active during frame", sel_err, 0);
    chk(dchg_err == 0, "R4", "data changes off falling edge", dchg_err, 0);
    bad_iv = 0;
    for (int i = 1; i < FB; i++) begin
      exp_d = per + ((gap && (i % pbits == 0)) ? GC * per : 0);
      if (edge_t[i] - edge_t[i-1] != exp_d) bad_iv++;
    end
    chk(bad_iv == 0, gap ? "R7" : "R6", "edge spacing errors", bad_iv, 0);
    chk(ssel_o == ~pol && sclk_o == 1'b1, "R5", "idle levels after frame", {ssel_o, sclk_o}, {~pol, 1'b1});
  endtask

  task automatic t_reserved();
    logic [1:0] codes [3] = '{2'b00, 2'b10, 2'b11};
    for (int c = 0; c < 3; c++) begin
      write_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b0, codes[c]));
      clear_mon();
      pulse_start();
      repeat (20) @(negedge clk);
      chk(busy_cnt == 0, "R9", "busy cycles with non-stream code", busy_cnt, 0);
      chk(nbits == 0 && ssel_o == 1'b1, "R9", "edges with non-stream code", nbits, 0);
    end
  endtask

  task automatic t_midframe();
    logic [FB-1:0] d1, e1;
    int bad_bits, idle_busy;
    d1 = mk_data(77);
    e1 = expect_stream(d1);
    write_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b0, 2'b01));
    frame_data = d1;
    mon_pol = 1'b0;
    clear_mon();
    pulse_start();
    repeat (50) @(negedge clk);
    write_cfg(mk_cfg(1'b1, 1'b1, 1'b1, 1'b1, 2'b01));
    frame_data = mk_data(99);
    pulse_start();
    wait_idle();
    @(negedge clk);
    bad_bits = $countones(got ^ e1);
    chk(bad_bits == 0, "R10", "data changed mid-frame", bad_bits, 0);
    chk(busy_cnt == expect_len(0, 0, 0), "R10", "length after mid-frame cfg write", busy_cnt, expect_len(0, 0, 0));
    chk(sel_err == 0, "R10", "polarity changed mid-frame", sel_err, 0);
    chk(cfg_q == mk_cfg(1'b1, 1'b1, 1'b1, 1'b1, 2'b01), "R2", "cfg holds mid-frame write", cfg_q, mk_cfg(1, 1, 1, 1, 2'b01));
    idle_busy = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy_o) idle_busy++;
    end
    chk(idle_busy == 0, "R11", "frame started by start while busy", idle_busy, 0);
    chk(ssel_o == 1'b0, "R5", "idle ssel with pol 1", ssel_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_rw();
    t_frame(1'b0, 1'b0, 1'b0, 1'b0, 1);
    t_frame(1'b1, 1'b1, 1'b1, 1'b1, 2);
    t_frame(1'b1, 1'b0, 1'b0, 1'b1, 3);
    t_frame(1'b0, 1'b1, 1'b1, 1'b0, 4);
    t_reserved();
    t_midframe();
    report();
    $finish;
  end

  initial begin
    #(5ns * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule